// File: doc/BRIEF.md
# Calendar clock interrupt flag unit

This block collects the event sources of a calendar clock into a set of sticky interrupt flags and merges them into one interrupt line. It watches the 256 Hz prescaler stage bits, the carry pulses of the second, minute and hour counters, the stopwatch count pulses, the end of a rate-trim operation, and a comparison between the current time and a programmed alarm time. Each event raises its own flag. The flag stays raised until software writes a 1 to that flag position.

Two of the sources are delayed on purpose. The periodic flags for 1/32 s, 1/8 s, 1/4 s, 1/2 s and 1 s come from falling edges of the prescaler bits. The alarm flag comes from the first sample at which the time matches. Both are sampled on the 256 Hz strobe and are raised one strobe later. The minute, hour, day, stopwatch and trim flags are raised in the clock cycle that follows their pulse.

Software supplies a per-flag enable mask. The interrupt output is high while any enabled flag is set.

Top module: `rtc_irq_top`

## Requirements
- R1: While `rst_n` is low, `flags` is all zero and `irq` is low.
- R2: Let a 256 Hz strobe find a falling edge on a prescaler bit, comparing its value with the value at the previous strobe. The matching flag is then set by the next strobe and is visible in the cycle after it. The pairs of prescaler bit and flag are: `presc[2]` (32 Hz) to `flags[0]`, `presc[4]` (8 Hz) to `flags[1]`, `presc[5]` (4 Hz) to `flags[2]`, `presc[6]` (2 Hz) to `flags[3]` and `presc[7]` (1 Hz) to `flags[4]`. `presc[0]` is the 128 Hz bit.
- R3: A one-cycle pulse on `sec_carry`, `min_carry` or `hour_carry` sets `flags[5]` (minute), `flags[6]` (hour) or `flags[7]` (day) in the next cycle.
- R4: A one-cycle pulse on `sw100_pulse`, `sw10_pulse`, `sw1_pulse` or `trim_done` sets `flags[9]`, `flags[10]`, `flags[11]` or `flags[12]` in the next cycle.
- R5: The alarm comparison always requires hour, minute and second to be equal. It also requires `cur_pm == alm_pm` only when `mode12` is 1; when `mode12` is 0 the AM/PM inputs have no effect.
- R6: When a strobe first samples a true match, `flags[8]` is set at the following strobe. A match that stays true is not taken again, so clearing the flag during a persistent match leaves it clear.
- R7: In a cycle with `clr_wr` high, every flag whose `clr_data` bit is 1 is cleared and every flag whose bit is 0 keeps its value. When `clr_wr` is low, `clr_data` has no effect.
- R8: If a flag is set and cleared in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `flags & irq_en` is non-zero, following `irq_en` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick256 | input | 1 | One-cycle 256 Hz strobe |
| presc | input | 8 | Prescaler stage bits, bit 0 = 128 Hz, bit 7 = 1 Hz |
| sec_carry | input | 1 | Second counter wrap pulse (minute count-up) |
| min_carry | input | 1 | Minute counter wrap pulse (hour count-up) |
| hour_carry | input | 1 | Hour counter wrap pulse (day count-up) |
| sw100_pulse | input | 1 | Stopwatch 1/100 s count pulse |
| sw10_pulse | input | 1 | Stopwatch 1/10 s count pulse |
| sw1_pulse | input | 1 | Stopwatch 1/10 s wrap pulse |
| trim_done | input | 1 | Rate-trim operation finished |
| mode12 | input | 1 | 1 = 12-hour mode, AM/PM takes part in the alarm match |
| cur_pm | input | 1 | Current AM/PM bit |
| cur_hour | input | 5 | Current hour |
| cur_min | input | 6 | Current minute |
| cur_sec | input | 6 | Current second |
| alm_pm | input | 1 | Alarm AM/PM bit |
| alm_hour | input | 5 | Alarm hour |
| alm_min | input | 6 | Alarm minute |
| alm_sec | input | 6 | Alarm second |
| clr_wr | input | 1 | Write strobe for the clear mask |
| clr_data | input | 13 | Clear mask, 1 clears the flag |
| irq_en | input | 13 | Per-flag interrupt enable |
| flags | output | 13 | Sticky flags |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the alarm behaviour across AM/PM and persistent matches. It depends on a time comparison that holds for many strobes, and a flag must be cleared while that match is still true. The stimulus holds the time fields steady over fixed windows: a 24-hour window where only AM/PM differs, a 12-hour window where only AM/PM differs, and a 12-hour window with a full match. During these windows the random clears are masked away from the alarm bit. A single clear inside the last window then shows that the flag does not come back. Every 97 cycles the bench also drives a carry pulse together with a full clear, so that set-versus-clear collisions happen often.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int NFLAG    = 13;
  localparam int PRESC_W  = 8;
  localparam int NSUB     = 5;
  localparam int F_SUB0   = 0;
  localparam int F_MIN    = 5;
  localparam int F_HOUR   = 6;
  localparam int F_DAY    = 7;
  localparam int F_ALM    = 8;
  localparam int F_SW100  = 9;
  localparam int F_SW10   = 10;
  localparam int F_SW1    = 11;
  localparam int F_TRIM   = 12;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rtc_irq_presc_edge.sv
module rtc_irq_presc_edge #(
  parameter int PRESC_W = 8,
  parameter int NTAP    = 5,
  parameter int SELW    = $clog2(PRESC_W),
  parameter logic [NTAP*SELW-1:0] TAPS = {3'd7, 3'd6, 3'd5, 3'd4, 3'd2}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [PRESC_W-1:0] presc,
  output logic [NTAP-1:0]    set_o
);
  logic [NTAP-1:0] tap_now;
  logic [NTAP-1:0] prev_q, prev_d;
  logic [NTAP-1:0] pend_q, pend_d;
  logic [NTAP-1:0] fall;
  logic            unused_presc_bits;

  assign unused_presc_bits = ^presc;

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      localparam int unsigned SEL = TAPS[k*SELW +: SELW];
      assign tap_now[k] = presc[SEL];
      assign fall[k]    = prev_q[k] & ~tap_now[k];
    end
  endgenerate

  always_comb begin
    prev_d = prev_q;
    pend_d = pend_q;
    set_o  = '0;
    if (tick) begin
      prev_d = tap_now;
      pend_d = fall;
      set_o  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  // R2: periodic flags are only raised on a strobe
  p_set_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_o != '0) |-> tick);
endmodule

// File: rtl/rtc_irq_alarm.sv
module rtc_irq_alarm #(
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              mode12,
  input  logic              cur_pm,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic              alm_pm,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  output logic              set_o
);
  logic match;
  logic time_eq;
  logic pm_ok;
  logic seen_q, seen_d;
  logic pend_q, pend_d;

  always_comb begin
    time_eq = (cur_hour == alm_hour) && (cur_min == alm_min) && (cur_sec == alm_sec);
    pm_ok   = !mode12 || (cur_pm == alm_pm);
    match   = time_eq && pm_ok;
  end

  always_comb begin
    seen_d = seen_q;
    pend_d = pend_q;
    set_o  = 1'b0;
    if (tick) begin
      seen_d = match;
      pend_d = match && !seen_q;
      set_o  = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
      pend_q <= pend_d;
    end
  end

  // R6: an alarm set is never repeated in back-to-back cycles
  p_alarm_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> !set_o);
  // R6: an alarm set follows a strobe that saw the match
  p_alarm_after_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> seen_q);
endmodule

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      logic clr_hit;
      always_comb begin
        clr_hit    = clr_wr & clr_mask[i];
        flags_d[i] = flags_q[i];
        if (clr_hit) flags_d[i] = 1'b0;
        if (set_i[i]) flags_d[i] = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q[i] <= 1'b0;
        else        flags_q[i] <= flags_d[i];
      end
    end
  endgenerate

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en);

  // R8: a set event always leaves its flag high
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));
  // R7: cleared flags without a set are low afterwards
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((flags_q & $past(clr_mask & ~set_i)) == '0));
  // R7: no write and no set keeps every flag
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && set_i == '0) |=> (flags_q == $past(flags_q)));
  // R9: with nothing enabled and set the line is low
  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & en) == '0) |-> !irq_o);
endmodule

// File: rtl/rtc_irq_top.sv
module rtc_irq_top
  import rtc_irq_pkg::*;
#(
  parameter int HOUR_W = 5,
  parameter int MIN_W  = 6,
  parameter int SEC_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick256,
  input  logic [7:0]        presc,
  input  logic              sec_carry,
  input  logic              min_carry,
  input  logic              hour_carry,
  input  logic              sw100_pulse,
  input  logic              sw10_pulse,
  input  logic              sw1_pulse,
  input  logic              trim_done,
  input  logic              mode12,
  input  logic              cur_pm,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic              alm_pm,
  input  logic [HOUR_W-1:0] alm_hour,
  input  logic [MIN_W-1:0]  alm_min,
  input  logic [SEC_W-1:0]  alm_sec,
  input  logic              clr_wr,
  input  logic [12:0]       clr_data,
  input  logic [12:0]       irq_en,
  output logic [12:0]       flags,
  output logic              irq
);
  localparam int SELW = $clog2(PRESC_W);

  logic [1:0]      rs_q;
  logic            rst_core_n;
  logic [NSUB-1:0] sub_set;
  logic            alm_set;
  flag_vec_t       set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  rtc_irq_presc_edge #(
    .PRESC_W(PRESC_W),
    .NTAP   (NSUB),
    .SELW   (SELW),
    .TAPS   ({3'd7, 3'd6, 3'd5, 3'd4, 3'd2})
  ) u_presc (
    .clk  (clk),
    .rst_n(rst_core_n),
    .tick (tick256),
    .presc(presc),
    .set_o(sub_set)
  );

  rtc_irq_alarm #(
    .HOUR_W(HOUR_W),
    .MIN_W (MIN_W),
    .SEC_W (SEC_W)
  ) u_alarm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .tick    (tick256),
    .mode12  (mode12),
    .cur_pm  (cur_pm),
    .cur_hour(cur_hour),
    .cur_min (cur_min),
    .cur_sec (cur_sec),
    .alm_pm  (alm_pm),
    .alm_hour(alm_hour),
    .alm_min (alm_min),
    .alm_sec (alm_sec),
    .set_o   (alm_set)
  );

  always_comb begin
    set_vec                        = '0;
    set_vec[F_SUB0 +: NSUB]        = sub_set;
    set_vec[F_MIN]                 = sec_carry;
    set_vec[F_HOUR]                = min_carry;
    set_vec[F_DAY]                 = hour_carry;
    set_vec[F_ALM]                 = alm_set;
    set_vec[F_SW100]               = sw100_pulse;
    set_vec[F_SW10]                = sw10_pulse;
    set_vec[F_SW1]                 = sw1_pulse;
    set_vec[F_TRIM]                = trim_done;
  end

  rtc_irq_flag_bank #(.N(NFLAG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_i   (set_vec),
    .clr_wr  (clr_wr),
    .clr_mask(clr_data),
    .en      (irq_en),
    .flags_o (flags),
    .irq_o   (irq)
  );

  // R6: the alarm source lands in its flag bit
  p_alarm_flag_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    alm_set |=> flags[F_ALM]);
  // R3: a minute carry lands in the minute flag
  p_min_flag_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    sec_carry |=> flags[F_MIN]);
endmodule

// File: tb/rtc_irq_top_test.sv
module rtc_irq_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick256, sec_carry, min_carry, hour_carry;
  logic        sw100_pulse, sw10_pulse, sw1_pulse, trim_done;
  logic        mode12, cur_pm, alm_pm;
  logic [7:0]  presc;
  logic [4:0]  cur_hour, alm_hour;
  logic [5:0]  cur_min, alm_min, cur_sec, alm_sec;
  logic        clr_wr;
  logic [12:0] clr_data, irq_en;
  logic [12:0] flags;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [12:0] m_flags;
  logic [12:0] pq[$];
  logic [7:0]  m_prev;
  logic        m_seen, m_apend, m_overlap;
  logic [7:0]  cnt;
  logic [31:0] lf;

  always #4 clk = ~clk;

  rtc_irq_top uut (
    .clk(clk), .rst_n(rst_n), .tick256(tick256), .presc(presc),
    .sec_carry(sec_carry), .min_carry(min_carry), .hour_carry(hour_carry),
    .sw100_pulse(sw100_pulse), .sw10_pulse(sw10_pulse), .sw1_pulse(sw1_pulse),
    .trim_done(trim_done), .mode12(mode12), .cur_pm(cur_pm),
    .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_pm(alm_pm), .alm_hour(alm_hour), .alm_min(alm_min), .alm_sec(alm_sec),
    .clr_wr(clr_wr), .clr_data(clr_data), .irq_en(irq_en),
    .flags(flags), .irq(irq)
  );

  function automatic string tag_of(int b);
    if (m_overlap) return "R8";
    if (b <= 4) return "R2";
    if (b <= 7) return "R3";
    if (b == 8) return "R6";
    return "R4";
  endfunction

  task automatic model_step();
    logic [12:0] setm, fallm, clrm;
    logic mt;
    if (!rst_n) begin
      m_flags = '0; m_prev = '0; pq.delete(); m_seen = 0; m_apend = 0; m_overlap = 0;
      return;
    end
    setm = '0;
    if (tick256) begin
      fallm = '0;
      fallm[0] = m_prev[2] && !presc[2];
      fallm[1] = m_prev[4] && !presc[4];
      fallm[2] = m_prev[5] && !presc[5];
      fallm[3] = m_prev[6] && !presc[6];
      fallm[4] = m_prev[7] && !presc[7];
      pq.push_back(fallm);
      if (pq.size() > 1) setm = setm | pq.pop_front();
      m_prev = presc;
      // R5: AM/PM only counts in 12-hour mode
      mt = (cur_hour == alm_hour) && (cur_min == alm_min) && (cur_sec == alm_sec)
           && (!mode12 || (cur_pm == alm_pm));
      if (m_apend) setm[8] = 1'b1;
      m_apend = mt && !m_seen;
      m_seen = mt;
    end
    setm[5] = setm[5] | sec_carry;
    setm[6] = setm[6] | min_carry;
    setm[7] = setm[7] | hour_carry;
    setm[9] = setm[9] | sw100_pulse;
    setm[10] = setm[10] | sw10_pulse;
    setm[11] = setm[11] | sw1_pulse;
    setm[12] = setm[12] | trim_done;
    clrm = clr_wr ? clr_data : 13'h0;
    m_overlap = |(setm & clrm);
    m_flags = (m_flags & ~clrm) | setm;
  endtask

  task automatic compare();
    logic exp_irq;
    for (int b = 0; b < 13; b++) begin
      checks++;
      if (flags[b] !== m_flags[b]) begin
        failures++;
        $display("FAIL %s flag %0d actual=%0b expected=%0b", rst_n ? tag_of(b) : "R1",
                 b, flags[b], m_flags[b]);
      end
    end
    exp_irq = |(m_flags & irq_en);
    checks++;
    if (irq !== exp_irq) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", rst_n ? "R9" : "R1", irq, exp_irq);
    end
  endtask

  task automatic directed(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s alarm flag actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive(int c);
    tick256 = 0; sec_carry = 0; min_carry = 0; hour_carry = 0;
    sw100_pulse = 0; sw10_pulse = 0; sw1_pulse = 0; trim_done = 0; clr_wr = 0;
    if (c < 6) return;
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
    if (c % 4 == 0) begin
      tick256 = 1; cnt = cnt + 8'd1; presc = cnt;
    end
    sec_carry   = (lf[3:0] == 4'd0);
    min_carry   = (lf[7:4] == 4'd1);
    hour_carry  = (lf[11:8] == 4'd2);
    sw100_pulse = (lf[15:12] == 4'd3);
    sw10_pulse  = (lf[19:16] == 4'd4);
    sw1_pulse   = (lf[23:20] == 4'd5);
    trim_done   = (lf[27:24] == 4'd6);
    clr_data    = lf[12:0] ^ lf[31:19];
    clr_wr      = (lf[30:28] == 3'd0);
    if (c % 97 == 0) begin
      sec_carry = 1; clr_wr = 1; clr_data = '1;   // R8 collision
    end
    if (c >= 1000 && c < 2400) clr_data[8] = 1'b0;
    if (c == 1500 || c == 2200) begin
      clr_wr = 1; clr_data = 13'h100;
    end
    if (c % 64 == 0) irq_en = lf[25:13];
    if (c % 256 == 128) irq_en = '0;
    mode12 = 0; cur_pm = 1; alm_pm = 0;
    cur_hour = 5'd11; cur_min = 6'd42; cur_sec = 6'd17;
    alm_hour = 5'd11; alm_min = 6'd42; alm_sec = 6'd18;
    if (c >= 1000 && c < 1400) alm_sec = 6'd17;
    else if (c >= 1600 && c < 2000) begin alm_sec = 6'd17; mode12 = 1; end
    else if (c >= 2000 && c < 2400) begin alm_sec = 6'd17; mode12 = 1; alm_pm = 1; end
    else if (c >= 2400) begin alm_sec = 6'd17; cur_sec = {2'b00, cnt[7:4]} + 6'd10; end
  endtask

  initial begin
    rst_n = 0; presc = '0; cnt = '0; lf = 32'h1234_5678;
    mode12 = 0; cur_pm = 0; alm_pm = 0;
    cur_hour = '0; cur_min = '0; cur_sec = '0;
    alm_hour = 5'd1; alm_min = '0; alm_sec = '0;
    clr_data = '0; irq_en = '1;
    drive(0);
    for (int r = 0; r < 6; r++) begin
      @(negedge clk);
      model_step();
      compare();   // R1 reset state
    end
    rst_n = 1;
    for (int c = 0; c < 3200; c++) begin
      @(negedge clk);
      model_step();
      compare();
      if (c == 1399) directed("R5", flags[8], 1'b1);
      if (c == 1999) directed("R5", flags[8], 1'b0);
      if (c == 2100) directed("R6", flags[8], 1'b1);
      if (c == 2399) directed("R6", flags[8], 1'b0);
      drive(c);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule